// File: doc/BRIEF.md
# Interrupt Vector Table Fetch Unit

This unit sits beside a core-local interrupt controller. It turns an accepted vectored interrupt into a handler address by reading it from a table in memory. The table starts at a base address held for the handling privilege level. The unit forms the entry address from that base and the interrupt number and issues one read on the instruction-fetch path. When the read returns, the unit sends the handler address to the program counter.

A table read can fault. The unit keeps an in-handler-vector flag, which is set while a table read is in progress and stays set if the read faults. On a fault the unit reports the faulting entry address, which must be written into the exception PC register of the mode that takes the fault. If that mode has the same privilege as the interrupt, the saved PC of the interrupted context is overwritten, and the unit flags this loss. If a trap return arrives while the flag is set, the unit reads the table again at the address in the exception PC instead of jumping to that address. Only one table read is in flight at a time.

Top module: `vtf_fetch_unit`

## Requirements
- R1: An interrupt accepted with number N against table base B reads the entry at ((B with its low log2(XLEN/8) bits cleared) + N*XLEN/8) modulo 2^XLEN.
- R2: Every table read is marked as an instruction fetch: mem_req_fetch is 1 exactly in the cycles when mem_req_valid is 1.
- R3: A faulting response raises epc_wr_valid for one cycle, in the cycle after the response. It carries the entry address that was read. The unit makes no PC redirect and inhv stays 1.
- R4: inhv is 1 from the cycle after an interrupt is accepted. It returns to 0 in the cycle after a response without a fault, and it is unchanged by anything else.
- R5: A response without a fault raises pc_redirect_valid for one cycle, in the cycle after the response. The address is the response data with bit 0 forced to 0.
- R6: A trap return accepted while inhv is 1 causes, from the next cycle, a table read at the address ret_epc. It makes no redirect to ret_epc itself.
- R7: A trap return accepted while inhv is 0 raises pc_redirect_valid in the next cycle, with ret_epc and bit 0 forced to 0. No table read is made.
- R8: Only one table read is outstanding. irq_ready and ret_ready are 0 from acceptance until the cycle after the response. A request not yet taken (mem_req_ready is 0) keeps its address. At most one of mem_req_valid, pc_redirect_valid and epc_wr_valid is 1 in any cycle.
- R9: epc_wr_upper copies mem_rsp_upper of the faulting response (1 = the fault goes to a more privileged mode). ctx_lost is 1 with the fault report exactly when epc_wr_upper is 0.
- R10: A trap return takes priority over an interrupt offered in the same idle cycle. irq_ready is 0 while ret_valid is 1.
- R11: During and right after reset, irq_ready and ret_ready are 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | Vectored interrupt offered |
| irq_id | input | ID_W | Interrupt number |
| irq_ready | output | 1 | Interrupt accepted this cycle when irq_valid is 1 |
| tbl_base | input | XLEN | Vector table base of the handling mode |
| ret_valid | input | 1 | Trap return offered |
| ret_epc | input | XLEN | Current exception PC value of the returning mode |
| ret_ready | output | 1 | Trap return accepted this cycle when ret_valid is 1 |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_req_fetch | output | 1 | Request is permission-checked as an instruction fetch |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | XLEN | Handler address read from the table |
| mem_rsp_fault | input | 1 | Access exception on the read |
| mem_rsp_upper | input | 1 | The fault traps to a more privileged mode |
| inhv | output | 1 | In-handler-vector flag |
| pc_redirect_valid | output | 1 | Write PC this cycle |
| pc_redirect_addr | output | XLEN | New PC |
| epc_wr_valid | output | 1 | Write exception PC with the faulting entry address |
| epc_wr_addr | output | XLEN | Faulting entry address |
| epc_wr_upper | output | 1 | Target is the more privileged mode's exception PC |
| ctx_lost | output | 1 | Same-level fault overwrote the interrupted context's saved PC |

## Verification
A wrong sequencer state shows at once at the ports. A stuck busy state holds irq_ready and ret_ready low. A missed busy state lets a second acceptance overlap a read, or it drops the request the cycle after acceptance. A corrupted held entry address shows on mem_req_addr during the request, or on epc_wr_addr one cycle after a faulting response. A wrong in-handler-vector flag is seen directly on inhv. It also shows on the next trap return, which then gives a redirect where a table read was due, or the other way round.

// File: rtl/vtf_pkg.sv
// Package for the vector table fetch unit.
// Holds the sequencer state encoding and a helper that forces a PC's bit 0 low.
package vtf_pkg;

    typedef enum logic [1:0] {
        VTF_IDLE = 2'd0,
        VTF_REQ  = 2'd1,
        VTF_WAIT = 2'd2
    } vtf_state_e;

    // Handler and return targets are halfword aligned: bit 0 is always cleared.
    function automatic logic [63:0] vtf_clr_lsb(input logic [63:0] a);
        return {a[63:1], 1'b0};
    endfunction

endpackage

// File: rtl/vtf_addr_gen.sv
// Entry address generator.
// Forms base + id * (XLEN/8) with the base aligned down to the entry size.
// Assumes ID_W <= XLEN and XLEN/8 is a power of two.
module vtf_addr_gen #(
    parameter int XLEN = 32,
    parameter int ID_W = 10
) (
    input  logic [XLEN-1:0] tbl_base,
    input  logic [ID_W-1:0] irq_id,
    output logic [XLEN-1:0] entry_addr
);
    localparam int ENTRY_BYTES = XLEN / 8;
    localparam int SHIFT       = $clog2(ENTRY_BYTES);

    logic [XLEN-1:0] base_mask;
    logic [XLEN-1:0] id_ext;

    // Build the alignment mask bit by bit so that any entry size works.
    for (genvar b = 0; b < XLEN; b++) begin : g_mask
        assign base_mask[b] = (b >= SHIFT);
    end

    // Scale the interrupt number into a byte offset and add it to the aligned base.
    always_comb begin
        id_ext     = XLEN'(irq_id);
        entry_addr = (tbl_base & base_mask) + (id_ext << SHIFT);
    end
endmodule

// File: rtl/vtf_ctrl.sv
// Sequencer for table reads.
// Accepts an interrupt or a trap return when idle, holds the entry address,
// drives a single outstanding request and owns the in-handler-vector flag.
// Assumes the memory answers each accepted request exactly once.
module vtf_ctrl
    import vtf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_valid,
    input  logic [XLEN-1:0] entry_addr,
    input  logic            ret_valid,
    input  logic [XLEN-1:0] ret_epc,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic            mem_rsp_fault,
    output logic            irq_ready,
    output logic            ret_ready,
    output logic            mem_req_valid,
    output logic [XLEN-1:0] mem_req_addr,
    output logic            mem_req_fetch,
    output logic            inhv,
    output logic            ok_evt,
    output logic            flt_evt,
    output logic            plain_ret,
    output logic [XLEN-1:0] held_addr
);
    vtf_state_e      state_q, state_d;
    logic [XLEN-1:0] addr_q, addr_d;
    logic            inhv_q, inhv_d;

    // Next-state decision: returns win over interrupts; responses close the read.
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        inhv_d    = inhv_q;
        ok_evt    = 1'b0;
        flt_evt   = 1'b0;
        plain_ret = 1'b0;
        unique case (state_q)
            VTF_IDLE: begin
                if (ret_valid) begin
                    if (inhv_q) begin
                        addr_d  = ret_epc;
                        state_d = VTF_REQ;
                    end else begin
                        plain_ret = 1'b1;
                    end
                end else if (irq_valid) begin
                    addr_d  = entry_addr;
                    inhv_d  = 1'b1;
                    state_d = VTF_REQ;
                end
            end
            VTF_REQ: begin
                if (mem_req_ready) state_d = VTF_WAIT;
            end
            VTF_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = VTF_IDLE;
                    if (mem_rsp_fault) begin
                        flt_evt = 1'b1;
                    end else begin
                        ok_evt = 1'b1;
                        inhv_d = 1'b0;
                    end
                end
            end
            default: state_d = VTF_IDLE;
        endcase
    end

    // State, address and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VTF_IDLE;
            addr_q  <= '0;
            inhv_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            inhv_q  <= inhv_d;
        end
    end

    // Port-side view of the sequencer.
    always_comb begin
        irq_ready     = (state_q == VTF_IDLE) && !ret_valid;
        ret_ready     = (state_q == VTF_IDLE);
        mem_req_valid = (state_q == VTF_REQ);
        mem_req_fetch = (state_q == VTF_REQ);
        mem_req_addr  = (state_q == VTF_REQ) ? addr_q : '0;
        inhv          = inhv_q;
        held_addr     = addr_q;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4
    inhv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_ready |=> inhv);
endmodule

// File: rtl/vtf_result.sv
// Result stage.
// Registers the one-cycle PC redirect and the fault report towards the
// exception PC, and flags the loss of the interrupted context on same-level faults.
module vtf_result
    import vtf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ok_evt,
    input  logic            flt_evt,
    input  logic            plain_ret,
    input  logic [XLEN-1:0] rsp_data,
    input  logic [XLEN-1:0] ret_epc,
    input  logic [XLEN-1:0] held_addr,
    input  logic            rsp_upper,
    output logic            pc_redirect_valid,
    output logic [XLEN-1:0] pc_redirect_addr,
    output logic            epc_wr_valid,
    output logic [XLEN-1:0] epc_wr_addr,
    output logic            epc_wr_upper,
    output logic            ctx_lost
);
    logic [XLEN-1:0] lsb_mask;
    assign lsb_mask = {{(XLEN-1){1'b1}}, 1'b0};

    // Redirect register: table data on success, saved PC on a plain return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_redirect_valid <= 1'b0;
            pc_redirect_addr  <= '0;
        end else begin
            pc_redirect_valid <= ok_evt || plain_ret;
            if (ok_evt)         pc_redirect_addr <= rsp_data & lsb_mask;
            else if (plain_ret) pc_redirect_addr <= ret_epc & lsb_mask;
            else                pc_redirect_addr <= '0;
        end
    end

    // Fault report register: faulting entry address and target mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_wr_valid <= 1'b0;
            epc_wr_addr  <= '0;
            epc_wr_upper <= 1'b0;
            ctx_lost     <= 1'b0;
        end else begin
            epc_wr_valid <= flt_evt;
            epc_wr_addr  <= flt_evt ? held_addr : '0;
            epc_wr_upper <= flt_evt && rsp_upper;
            ctx_lost     <= flt_evt && !rsp_upper;
        end
    end
endmodule

// File: rtl/vtf_fetch_unit.sv
// Interrupt vector table fetch unit, top level.
// Connects the entry address generator, the read sequencer and the result stage.
// Assumes the memory returns one response per accepted request, and
// that ret_epc already holds the value the returning mode saved.
module vtf_fetch_unit #(
    parameter int XLEN = 32,
    parameter int ID_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_valid,
    input  logic [ID_W-1:0] irq_id,
    output logic            irq_ready,
    input  logic [XLEN-1:0] tbl_base,
    input  logic            ret_valid,
    input  logic [XLEN-1:0] ret_epc,
    output logic            ret_ready,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    output logic            mem_req_fetch,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            mem_rsp_fault,
    input  logic            mem_rsp_upper,
    output logic            inhv,
    output logic            pc_redirect_valid,
    output logic [XLEN-1:0] pc_redirect_addr,
    output logic            epc_wr_valid,
    output logic [XLEN-1:0] epc_wr_addr,
    output logic            epc_wr_upper,
    output logic            ctx_lost
);
    logic [XLEN-1:0] entry_addr;
    logic [XLEN-1:0] held_addr;
    logic            ok_evt, flt_evt, plain_ret;

    vtf_addr_gen #(.XLEN(XLEN), .ID_W(ID_W)) addr_gen_i (
        .tbl_base   (tbl_base),
        .irq_id     (irq_id),
        .entry_addr (entry_addr)
    );

    vtf_ctrl #(.XLEN(XLEN)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_valid     (irq_valid),
        .entry_addr    (entry_addr),
        .ret_valid     (ret_valid),
        .ret_epc       (ret_epc),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_fault (mem_rsp_fault),
        .irq_ready     (irq_ready),
        .ret_ready     (ret_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_fetch (mem_req_fetch),
        .inhv          (inhv),
        .ok_evt        (ok_evt),
        .flt_evt       (flt_evt),
        .plain_ret     (plain_ret),
        .held_addr     (held_addr)
    );

    vtf_result #(.XLEN(XLEN)) result_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .ok_evt            (ok_evt),
        .flt_evt           (flt_evt),
        .plain_ret         (plain_ret),
        .rsp_data          (mem_rsp_data),
        .ret_epc           (ret_epc),
        .held_addr         (held_addr),
        .rsp_upper         (mem_rsp_upper),
        .pc_redirect_valid (pc_redirect_valid),
        .pc_redirect_addr  (pc_redirect_addr),
        .epc_wr_valid      (epc_wr_valid),
        .epc_wr_addr       (epc_wr_addr),
        .epc_wr_upper      (epc_wr_upper),
        .ctx_lost          (ctx_lost)
    );

    // R3
    fault_inhv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epc_wr_valid |-> inhv);

    // R4
    redirect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect_valid |-> !inhv);

    // R8
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, pc_redirect_valid, epc_wr_valid}));
endmodule

// File: tb/vtf_fetch_unit_tb.sv
// Bench for the vector table fetch unit: behavioural reference model,
// memory responder with random latency and faults, compared every cycle.
module vtf_fetch_unit_tb_top;
    localparam int XLEN = 32;
    localparam int ID_W = 10;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT = 2;
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n;
    logic irq_valid;
    logic [ID_W-1:0] irq_id;
    logic irq_ready;
    logic [XLEN-1:0] tbl_base;
    logic ret_valid;
    logic [XLEN-1:0] ret_epc;
    logic ret_ready;
    logic mem_req_valid, mem_req_ready, mem_req_fetch;
    logic [XLEN-1:0] mem_req_addr;
    logic mem_rsp_valid, mem_rsp_fault, mem_rsp_upper;
    logic [XLEN-1:0] mem_rsp_data;
    logic inhv, pc_redirect_valid, epc_wr_valid, epc_wr_upper, ctx_lost;
    logic [XLEN-1:0] pc_redirect_addr, epc_wr_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtf_fetch_unit #(.XLEN(XLEN), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_ready(irq_ready),
        .tbl_base(tbl_base), .ret_valid(ret_valid), .ret_epc(ret_epc), .ret_ready(ret_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_fetch(mem_req_fetch),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_fault(mem_rsp_fault), .mem_rsp_upper(mem_rsp_upper),
        .inhv(inhv), .pc_redirect_valid(pc_redirect_valid), .pc_redirect_addr(pc_redirect_addr),
        .epc_wr_valid(epc_wr_valid), .epc_wr_addr(epc_wr_addr),
        .epc_wr_upper(epc_wr_upper), .ctx_lost(ctx_lost)
    );

    // Reference model state: 0 idle, 1 request, 2 waiting for data.
    int m_state;
    logic [XLEN-1:0] m_addr;
    bit m_from_ret, m_inhv;
    bit m_rv, m_fv, m_fhi, m_lost;
    logic [XLEN-1:0] m_rpc, m_faddr;

    // Memory responder and system state.
    bit pend;
    int lat;
    logic [XLEN-1:0] pend_addr;
    bit fault_en;
    logic [XLEN-1:0] sys_epc;
    bit in_reset;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string t;
        t = in_reset ? "R11" : "R8";
        check(in_reset ? "R11" : "R10", "irq_ready", 64'(irq_ready),
              64'((m_state == 0) && !ret_valid));
        check(t, "ret_ready", 64'(ret_ready), 64'(m_state == 0));
        check(in_reset ? "R11" : (m_from_ret ? "R6" : "R8"), "mem_req_valid",
              64'(mem_req_valid), 64'(m_state == 1));
        if (m_state == 1)
            check(m_from_ret ? "R6" : "R1", "mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
        check(in_reset ? "R11" : "R2", "mem_req_fetch", 64'(mem_req_fetch), 64'(m_state == 1));
        check(in_reset ? "R11" : "R4", "inhv", 64'(inhv), 64'(m_inhv));
        check(in_reset ? "R11" : "R5", "pc_redirect_valid", 64'(pc_redirect_valid), 64'(m_rv));
        if (m_rv) check("R7", "pc_redirect_addr", 64'(pc_redirect_addr), 64'(m_rpc));
        check(in_reset ? "R11" : "R3", "epc_wr_valid", 64'(epc_wr_valid), 64'(m_fv));
        if (m_fv) begin
            check("R3", "epc_wr_addr", 64'(epc_wr_addr), 64'(m_faddr));
            check("R9", "epc_wr_upper", 64'(epc_wr_upper), 64'(m_fhi));
            check("R9", "ctx_lost", 64'(ctx_lost), 64'(m_lost));
        end else begin
            check(in_reset ? "R11" : "R9", "ctx_lost idle", 64'(ctx_lost), 64'd0);
        end
    endtask

    // Advance the reference model over one rising edge using the stable inputs.
    task automatic model_step();
        m_rv = 0; m_fv = 0; m_fhi = 0; m_lost = 0;
        if (!rst_n) begin
            m_state = 0; m_addr = '0; m_inhv = 0; m_from_ret = 0;
            return;
        end
        case (m_state)
            0: begin
                if (ret_valid) begin
                    if (m_inhv) begin
                        m_addr = ret_epc; m_state = 1; m_from_ret = 1;
                    end else begin
                        m_rv = 1; m_rpc = ret_epc & ~32'd1;
                    end
                end else if (irq_valid) begin
                    m_addr = ((tbl_base >> SHIFT) << SHIFT) + (XLEN'(irq_id) << SHIFT);
                    m_inhv = 1; m_state = 1; m_from_ret = 0;
                    sys_epc = {$urandom} & ~32'd1;
                end
            end
            1: if (mem_req_ready) m_state = 2;
            default: if (mem_rsp_valid) begin
                m_state = 0;
                if (mem_rsp_fault) begin
                    m_fv = 1; m_faddr = m_addr; m_fhi = mem_rsp_upper; m_lost = !mem_rsp_upper;
                    if (!mem_rsp_upper) sys_epc = m_addr;
                end else begin
                    m_rv = 1; m_rpc = mem_rsp_data & ~32'd1; m_inhv = 0;
                end
            end
        endcase
    endtask

    // Main stimulus loop: drive at falling edge, compare, then step the model.
    initial begin
        bit take;
        rst_n = 0; irq_valid = 0; irq_id = '0; tbl_base = 32'h0000_4000;
        ret_valid = 0; ret_epc = '0; mem_req_ready = 0;
        mem_rsp_valid = 0; mem_rsp_data = '0; mem_rsp_fault = 0; mem_rsp_upper = 0;
        pend = 0; lat = 0; fault_en = 0; sys_epc = 32'h100; in_reset = 1;
        m_state = 0; m_addr = '0; m_inhv = 0; m_from_ret = 0;
        m_rv = 0; m_fv = 0; m_fhi = 0; m_lost = 0; m_rpc = '0; m_faddr = '0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            in_reset = (cyc < 4);
            rst_n = !(cyc < 3);
            fault_en = ((cyc / 500) % 2) == 1;
            // Interrupt and return offers.
            irq_valid = ($urandom % 3) == 0;
            case ($urandom % 8)
                0: irq_id = '0;
                1: irq_id = '1;
                default: irq_id = ID_W'($urandom);
            endcase
            if (($urandom % 16) == 0) tbl_base = $urandom;
            ret_valid = m_inhv ? (($urandom % 3) == 0) : (($urandom % 10) == 0);
            ret_epc = (($urandom % 10) == 0) ? (sys_epc | 32'd1) : sys_epc;
            mem_req_ready = ($urandom % 3) != 0;
            // Memory response for an outstanding read.
            mem_rsp_valid = 0; mem_rsp_fault = 0; mem_rsp_upper = 0; mem_rsp_data = $urandom;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_fault = fault_en && (((pend_addr >> SHIFT) % 3) == 0);
                    mem_rsp_upper = $urandom % 2;
                    mem_rsp_data = pend_addr * 5 + 32'h1235;
                end else begin
                    lat--;
                end
            end
            #1;
            compare_all();
            take = mem_req_valid && mem_req_ready;
            @(posedge clk);
            if (mem_rsp_valid) pend = 0;
            if (take) begin
                pend = 1; pend_addr = m_addr; lat = $urandom % 4;
            end
            model_step();
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule